// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a clocked single-port memory with a 32-bit word split into four byte lanes. On every rising clock edge it looks at three select inputs, two address strobes and a step input. From them it picks one action: drop the cycle, open a burst at the address on the `addr` pins, move to the next word of the burst, or stay on the current word. The write controls are decoded alongside that action. They give a write of every lane, a write of chosen lanes only, or a read.

One strobe is meant for a processor. Whenever the device is selected and `sel_a_n` is low, it always opens a read. The other strobe is meant for a cache controller. It opens either a read or a write, depending on the write controls. Bursts cover four words inside an aligned block. The word order is either a wrapping count or an XOR walk, chosen by a mode input. A second mode input selects a fast path, where read data comes straight from the array's read register, or a registered path, which adds one edge of latency. The bus enable is asynchronous. The standby input is also asynchronous: it freezes the whole block and stops it from driving.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A cycle is dropped (no access, no write, no read data) when `sel_b` is low, or when `sel_c_n` is high, or when `ctl_strobe_n` is low while `sel_a_n` is high. "Selected" means `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0.
- R2: With `cpu_strobe_n` low and the device selected, a read burst opens at `addr`, whatever the write inputs are, and memory is left unchanged.
- R3: With `ctl_strobe_n` low, `cpu_strobe_n` high and the device selected, a burst opens at `addr`. It is a write of the decoded lanes if any lane is decoded (R7, R8), and a read otherwise. Write data is taken on that same edge.
- R4: With both strobes high, `step_n`=0 moves to the next burst word and `step_n`=1 stays on the current word. The cycle reads or writes that word according to the lane decode. Write data is taken on each such edge.
- R5: While `sel_a_n` is high, `cpu_strobe_n` is ignored, so the burst still steps or holds.
- R6: A burst keeps `addr[5:2]` of its start address. The low two bits for word k (k=0..3) are (start+k) mod 4 when `ord_linear`=1, and start XOR k when `ord_linear`=0.
- R7: `wr_all_n`=0 writes all four lanes, whatever `lane_gate_n` and `lane_en_n` are.
- R8: With `wr_all_n`=1 and `lane_gate_n`=0, lane i is written only if `lane_en_n[i]`=0. Lane i covers bits 8i+7:8i.
- R9: The cycle is a read when `wr_all_n`=1 and `lane_gate_n`=1, or when `lane_gate_n`=0 and all of `lane_en_n` are high.
- R10: With `fast_out`=1, read data is on `rdata` after the edge that sampled the read. With `fast_out`=0, it appears one edge later.
- R11: `rdata_oe` is high only while read data is presented and `bus_en_n` is low. `bus_en_n` acts without a clock. `rdata` is zero whenever `rdata_oe` is low. Driving stops after the edge that samples a dropped or write cycle in fast mode, and one edge later in registered mode. Both are low after reset.
- R12: While `sleep` is high, clock edges change neither memory nor burst position, and `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Burst start address |
| sel_a_n | input | 1 | Select, active low; also gates the processor strobe |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, opens reads |
| ctl_strobe_n | input | 1 | Controller address strobe, opens reads or writes |
| step_n | input | 1 | Low: move to next burst word; high: hold |
| wr_all_n | input | 1 | Low: write every lane |
| lane_gate_n | input | 1 | Low: per-lane write enables take effect |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*LW | Write data |
| fast_out | input | 1 | 1: fast read path, 0: registered read path |
| ord_linear | input | 1 | 1: wrapping count order, 0: XOR order |
| bus_en_n | input | 1 | Asynchronous data bus enable, active low |
| sleep | input | 1 | Asynchronous standby, freezes the block |
| rdata | output | LANES*LW | Read data, zero when not driven |
| rdata_oe | output | 1 | High while the data bus is driven |

## Verification
The bench fills blocks with bursts of whole-word writes opened by the controller strobe. It then reads them back through the processor strobe, first with the count order and then with the XOR order. A start offset of 1 is used so that the two orders give different word sequences. Held bursts, partial-lane writes mixed with stepping and holding, and write decodes that turn into reads show that the lane decode is applied per cycle and to the right word. Each select pattern that drops a cycle is tried while write inputs are active, and a later readback proves nothing was written. The same bursts are repeated on the registered path to expose the extra edge of latency, and standby is applied in the middle of a burst to show that the burst position survives.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    typedef enum logic [1:0] {
        ACT_DESEL = 2'd0,
        ACT_START = 2'd1,
        ACT_NEXT  = 2'd2,
        ACT_HOLD  = 2'd3
    } act_e;
endpackage

// File: rtl/bsram_cycle_dec.sv
module bsram_cycle_dec
    import bsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_en_n,
    output act_e             act,
    output logic [LANES-1:0] lane_we
);
    logic             chosen;
    logic [LANES-1:0] term_mask;

    always_comb begin
        chosen = !sel_a_n && sel_b && !sel_c_n;
        // global write dominates; per-lane enables only behind the gate
        if (!wr_all_n)
            term_mask = '1;
        else if (!lane_gate_n)
            term_mask = ~lane_en_n;
        else
            term_mask = '0;

        act     = ACT_HOLD;
        lane_we = '0;
        if (!cpu_strobe_n && !sel_a_n) begin
            // processor strobe: read only, write inputs ignored
            act = chosen ? ACT_START : ACT_DESEL;
        end else if (!ctl_strobe_n) begin
            if (chosen) begin
                act     = ACT_START;
                lane_we = term_mask;
            end else begin
                act = ACT_DESEL;
            end
        end else begin
            act     = step_n ? ACT_HOLD : ACT_NEXT;
            lane_we = term_mask;
        end
    end
endmodule

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq #(
    parameter int OW = 2
) (
    input  logic [OW-1:0] first_lo,
    input  logic [OW-1:0] idx,
    input  logic          linear,
    output logic [OW-1:0] lo
);
    always_comb begin
        if (linear)
            lo = first_lo + idx;
        else
            lo = first_lo ^ idx;
    end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic [LANES-1:0]    we,
    input  logic                re,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we[g])
                mem[addr] <= wdata[g*LW +: LW];
            if (re)
                rdata[g*LW +: LW] <= mem[addr];
        end
    end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import bsram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 8,
    parameter int BB    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                cpu_strobe_n,
    input  logic                ctl_strobe_n,
    input  logic                step_n,
    input  logic                wr_all_n,
    input  logic                lane_gate_n,
    input  logic [LANES-1:0]    lane_en_n,
    input  logic [LANES*LW-1:0] wdata,
    input  logic                fast_out,
    input  logic                ord_linear,
    input  logic                bus_en_n,
    input  logic                sleep,
    output logic [LANES*LW-1:0] rdata,
    output logic                rdata_oe
);
    localparam int DW = LANES * LW;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [BB-1:0] cnt;
        logic          rd_vld;
        logic          pipe_vld;
        logic [DW-1:0] pipe_data;
    } st_t;

    st_t              st_q, st_d;
    act_e             act;
    logic [LANES-1:0] lane_we;
    logic [BB-1:0]    idx;
    logic [BB-1:0]    seq_lo;
    logic [AW-1:0]    used_addr;
    logic             is_rd;
    logic [LANES-1:0] arr_we;
    logic             arr_re;
    logic [DW-1:0]    arr_rdata;
    logic             out_vld;
    logic [DW-1:0]    out_data;

    bsram_cycle_dec #(.LANES(LANES)) dec_i (
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .step_n       (step_n),
        .wr_all_n     (wr_all_n),
        .lane_gate_n  (lane_gate_n),
        .lane_en_n    (lane_en_n),
        .act          (act),
        .lane_we      (lane_we)
    );

    always_comb begin
        idx = (act == ACT_NEXT) ? st_q.cnt + 1'b1 : st_q.cnt;
    end

    bsram_burst_seq #(.OW(BB)) seq_i (
        .first_lo (st_q.base[BB-1:0]),
        .idx      (idx),
        .linear   (ord_linear),
        .lo       (seq_lo)
    );

    always_comb begin
        if (act == ACT_START)
            used_addr = addr;
        else
            used_addr = {st_q.base[AW-1:BB], seq_lo};
        is_rd  = (act != ACT_DESEL) && (lane_we == '0);
        arr_we = lane_we & {LANES{!sleep}};
        arr_re = is_rd && !sleep;
    end

    bsram_array #(.AW(AW), .LANES(LANES), .LW(LW)) arr_i (
        .clk   (clk),
        .we    (arr_we),
        .re    (arr_re),
        .addr  (used_addr),
        .wdata (wdata),
        .rdata (arr_rdata)
    );

    // next-state process
    always_comb begin
        st_d = st_q;
        if (!sleep) begin
            case (act)
                ACT_START: begin
                    st_d.base = addr;
                    st_d.cnt  = '0;
                end
                ACT_NEXT: st_d.cnt = idx;
                default: ;
            endcase
            st_d.rd_vld    = is_rd;
            st_d.pipe_vld  = st_q.rd_vld;
            st_d.pipe_data = arr_rdata;
        end
    end

    // register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        out_vld  = fast_out ? st_q.rd_vld : st_q.pipe_vld;
        out_data = fast_out ? arr_rdata   : st_q.pipe_data;
        rdata_oe = out_vld && !bus_en_n && !sleep;
        rdata    = rdata_oe ? out_data : '0;
    end

    AST_CPU_OPENS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !cpu_strobe_n && !sel_a_n && sel_b && !sel_c_n) |=> st_q.rd_vld); // R2
    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !wr_all_n && !ctl_strobe_n && cpu_strobe_n && !sel_a_n && sel_b && !sel_c_n)
        |-> (arr_we == '1)); // R7
    AST_DESEL_STOPS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && fast_out && act == ACT_DESEL) |=> !rdata_oe); // R11
    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(st_q)); // R12
    AST_PIPE_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> (st_q.pipe_vld == $past(st_q.rd_vld))); // R10
endmodule

// File: tb/burst_sram_ctrl_tb_top.sv
module burst_sram_ctrl_tb_top;
    localparam int AW = 6;
    localparam int LANES = 4;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic [AW-1:0] addr;
    logic sel_a_n, sel_b, sel_c_n, cpu_strobe_n, ctl_strobe_n, step_n;
    logic wr_all_n, lane_gate_n;
    logic [LANES-1:0] lane_en_n;
    logic [DW-1:0] wdata;
    logic fast_out, ord_linear, bus_en_n, sleep;
    logic [DW-1:0] rdata;
    logic rdata_oe;

    burst_sram_ctrl #(.AW(AW), .LANES(LANES), .LW(8), .BB(2)) dut_i (.*);

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] ref_mem [64];
    int  ref_base = 0;
    int  ref_cnt  = 0;
    bit  auto_exp = 1'b1;
    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;

    typedef struct {
        int          due;
        bit          oe;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] want);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, got, want);
        end
    endtask

    function automatic int word_lo(int lo, int k);
        return ord_linear ? ((lo + k) & 3) : (lo ^ k);
    endfunction

    task automatic push(int due, bit oe, logic [31:0] d, string tag);
        exp_t e;
        e.due = due; e.oe = oe; e.data = d; e.tag = tag;
        sbq.push_back(e);
    endtask

    // driver: applies one cycle, updates the reference model, queues the result
    task automatic drive(bit a_n, bit b, bit c_n, bit cpu_n, bit ctl_n, bit s_n,
                         bit wa_n, bit g_n, logic [3:0] le_n, logic [31:0] wd,
                         int ad, string tag);
        int used;
        bit sel, rd, dsl;
        logic [3:0] m;
        sel_a_n = a_n; sel_b = b; sel_c_n = c_n;
        cpu_strobe_n = cpu_n; ctl_strobe_n = ctl_n; step_n = s_n;
        wr_all_n = wa_n; lane_gate_n = g_n; lane_en_n = le_n;
        wdata = wd; addr = ad[AW-1:0];
        if (!sleep) begin
            sel = !a_n && b && !c_n;
            dsl = 1'b0;
            m = !wa_n ? 4'hF : (!g_n ? ~le_n : 4'h0);
            if (!cpu_n && !a_n) begin
                dsl = !sel; m = 4'h0;
                if (sel) begin ref_base = ad; ref_cnt = 0; end
            end else if (!ctl_n) begin
                dsl = !sel;
                if (sel) begin ref_base = ad; ref_cnt = 0; end
                else m = 4'h0;
            end else if (!s_n) begin
                ref_cnt = (ref_cnt + 1) & 3;
            end
            used = (ref_base & ~3) | word_lo(ref_base & 3, ref_cnt);
            rd = !dsl && (m == 4'h0);
            if (!dsl)
                for (int i = 0; i < 4; i++)
                    if (m[i]) ref_mem[used][i*8 +: 8] = wd[i*8 +: 8];
            if (auto_exp)
                push(cyc + (fast_out ? 1 : 2), rd, rd ? ref_mem[used] : 32'h0, tag);
        end
        @(posedge clk); #2;
    endtask

    task automatic desel(string t);
        drive(1, 1, 0, 1, 0, 1, 1, 1, 4'hF, 32'h0, 0, t);
    endtask
    task automatic cpu_rd(int ad, bit wa_n, string t);
        drive(0, 1, 0, 0, 1, 1, wa_n, 1, 4'hF, 32'hDEAD_BEEF, ad, t);
    endtask
    task automatic ctl_st(int ad, bit wa_n, bit g_n, logic [3:0] le_n, logic [31:0] wd, string t);
        drive(0, 1, 0, 1, 0, 1, wa_n, g_n, le_n, wd, ad, t);
    endtask
    task automatic cont(bit s_n, bit wa_n, bit g_n, logic [3:0] le_n, logic [31:0] wd, string t);
        drive(0, 1, 0, 1, 1, s_n, wa_n, g_n, le_n, wd, 0, t);
    endtask
    task automatic drain();
        repeat (3) desel("R11 idle");
        while (sbq.size() > 0) @(negedge clk);
        @(posedge clk); #2;
    endtask

    // monitor: compares queued expectations in their due window
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            if (e.due < cyc)
                chk(1'b0, {e.tag, " missed window"}, 32'(cyc), 32'(e.due));
            else begin
                chk(rdata_oe == e.oe, {e.tag, " drive"}, 32'(rdata_oe), 32'(e.oe));
                if (e.oe)
                    chk(rdata == e.data, {e.tag, " data"}, rdata, e.data);
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        sel_a_n = 1; sel_b = 1; sel_c_n = 0; cpu_strobe_n = 1; ctl_strobe_n = 0;
        step_n = 1; wr_all_n = 1; lane_gate_n = 1; lane_en_n = 4'hF;
        wdata = 0; addr = 0; fast_out = 1; ord_linear = 1; bus_en_n = 0; sleep = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(rdata_oe == 1'b0, "R11 reset drive", 32'(rdata_oe), 32'h0);
        chk(rdata == 32'h0, "R11 reset data", rdata, 32'h0);
        @(posedge clk); #2;

        // R7 R4 R6: whole-word write burst from offset 2, linear order
        ctl_st(6'h12, 0, 1, 4'hF, 32'hA0A0_0000, "R7 start write");
        cont(0, 0, 1, 4'hF, 32'hA1A1_1111, "R4 step write");
        cont(0, 0, 1, 4'hF, 32'hA2A2_2222, "R4 step write");
        cont(0, 0, 1, 4'hF, 32'hA3A3_3333, "R4 step write");
        desel("R1 after write");
        // R2: processor strobe reads despite global write asserted
        cpu_rd(6'h12, 0, "R2 cpu read");
        cont(0, 1, 1, 4'hF, 0, "R6 linear step");
        cont(0, 1, 1, 4'hF, 0, "R6 linear step");
        cont(0, 1, 1, 4'hF, 0, "R6 linear step");
        desel("R11 fast deselect");
        // R6: XOR order from offset 1
        drain();
        ord_linear = 0;
        cpu_rd(6'h11, 1, "R6 xor start");
        cont(0, 1, 1, 4'hF, 0, "R6 xor step");
        cont(0, 1, 1, 4'hF, 0, "R6 xor step");
        cont(0, 1, 1, 4'hF, 0, "R6 xor step");
        // R4: hold
        cpu_rd(6'h10, 1, "R4 start");
        cont(1, 1, 1, 4'hF, 0, "R4 hold");
        cont(1, 1, 1, 4'hF, 0, "R4 hold");
        cont(0, 1, 1, 4'hF, 0, "R4 step after hold");
        desel("R1 idle");
        // R8: fill block 0x20, then partial lanes
        ctl_st(6'h20, 0, 1, 4'hF, 32'hB0B1_B2B3, "R7 fill");
        cont(0, 0, 1, 4'hF, 32'hC0C1_C2C3, "R7 fill");
        cont(0, 0, 1, 4'hF, 32'hD0D1_D2D3, "R7 fill");
        cont(0, 0, 1, 4'hF, 32'hE0E1_E2E3, "R7 fill");
        ctl_st(6'h21, 1, 0, 4'b1110, 32'h1122_3344, "R8 lane0 write");
        cont(0, 1, 0, 4'b0101, 32'h5566_7788, "R8 lanes 1,3 step");
        cont(1, 1, 0, 4'b0111, 32'h99AA_BBCC, "R8 lane3 hold");
        cpu_rd(6'h20, 1, "R8 readback");
        cont(0, 1, 1, 4'hF, 0, "R8 readback");
        cont(0, 1, 1, 4'hF, 0, "R8 readback");
        cont(0, 1, 1, 4'hF, 0, "R8 readback");
        // R9 R3: controller strobe with no lane decoded reads
        ctl_st(6'h22, 1, 0, 4'hF, 32'hFFFF_FFFF, "R9 R3 ctl read gated");
        cont(0, 1, 1, 4'h0, 32'hFFFF_FFFF, "R9 read ungated");
        desel("R1 idle");
        // R5: processor strobe ignored while sel_a_n high
        cpu_rd(6'h13, 1, "R5 start");
        drive(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 0, 0, "R5 cpu ignored");
        // R1: each dropping pattern, write inputs active
        drive(0, 0, 0, 1, 0, 1, 0, 1, 4'hF, 32'h1234_5678, 6'h10, "R1 sel_b low");
        cpu_rd(6'h12, 1, "R1 read");
        drive(0, 1, 1, 0, 1, 1, 0, 1, 4'hF, 32'h5555_5555, 6'h10, "R1 sel_c high");
        cpu_rd(6'h13, 1, "R1 read");
        drive(1, 1, 0, 1, 0, 1, 0, 1, 4'hF, 32'h7777_7777, 6'h10, "R1 sel_a high");
        // R10: registered path
        drain();
        fast_out = 0; ord_linear = 1;
        cpu_rd(6'h10, 1, "R10 pipe read");
        cont(0, 1, 1, 4'hF, 0, "R10 pipe step");
        cont(0, 1, 1, 4'hF, 0, "R10 pipe step");
        cont(0, 1, 1, 4'hF, 0, "R10 pipe step");
        desel("R11 pipe deselect");
        ctl_st(6'h10, 1, 1, 4'hF, 0, "R3 pipe ctl read");
        ctl_st(6'h30, 0, 1, 4'hF, 32'h0BAD_F00D, "R11 pipe write");
        cpu_rd(6'h30, 1, "R10 pipe readback");
        drain();
        fast_out = 1;
        // R11: bus enable acts without a clock
        auto_exp = 0;
        cpu_rd(6'h10, 1, "R11");
        @(negedge clk);
        chk(rdata_oe == 1'b1, "R11 driven", 32'(rdata_oe), 32'h1);
        chk(rdata == ref_mem[6'h10], "R11 data", rdata, ref_mem[6'h10]);
        #1 bus_en_n = 1;
        #1 chk(rdata_oe == 1'b0 && rdata == 0, "R11 async release", rdata, 32'h0);
        bus_en_n = 0;
        #1 chk(rdata_oe == 1'b1, "R11 async redrive", 32'(rdata_oe), 32'h1);
        @(posedge clk); #2;
        desel("R11");
        @(negedge clk);
        chk(rdata_oe == 1'b0, "R11 fast deselect", 32'(rdata_oe), 32'h0);
        @(posedge clk); #2;
        // R12: standby
        ord_linear = 1;
        cpu_rd(6'h20, 1, "R12");
        sleep = 1;
        @(negedge clk);
        chk(rdata_oe == 1'b0, "R12 sleep float", 32'(rdata_oe), 32'h0);
        @(posedge clk); #2;
        ctl_st(6'h20, 0, 1, 4'hF, 32'hFFFF_FFFF, "R12 write in sleep");
        cont(0, 0, 1, 4'hF, 32'hEEEE_EEEE, "R12 step in sleep");
        cont(0, 0, 1, 4'hF, 32'hDDDD_DDDD, "R12 step in sleep");
        @(negedge clk);
        chk(rdata_oe == 1'b0, "R12 sleep float", 32'(rdata_oe), 32'h0);
        @(posedge clk); #2;
        sleep = 0;
        auto_exp = 1;
        cont(0, 1, 1, 4'hF, 0, "R12 burst resumes");
        cpu_rd(6'h20, 1, "R12 memory kept");
        cont(0, 1, 1, 4'hF, 0, "R12 memory kept");
        drain();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule